// File: doc/BRIEF.md
# MSI Termination and Coalescing Unit

This block terminates message-signalled interrupts that a PCIe root port delivers as memory writes into a dedicated window. Each accepted write is decoded into a group and an index register from its offset. The write data is a bit number, and the block sets that single pending bit in the addressed register. The 2688 vectors are spread over 16 groups of 8 registers, with 21 pending bits in each register. Every group drives one level interrupt line, so all the vectors share 16 lines.

To service a line, software first reads the group's summary register. Bit i of the summary shows that index register i of the group holds pending bits. Software then reads each flagged index register. That read returns the pending bits and clears them in the same operation. Software rebuilds each vector number as ((index*21 + bit)*16) + group. The block ignores and counts writes that are malformed. A per-group enable mask can hold a line low while its pending state is kept.

A small read state machine has two named states. RD_IDLE means no response is due. RD_RESP means read data is presented on this cycle. The transitions are:
- RD_IDLE to RD_RESP when a read is requested.
- RD_RESP to RD_RESP when another read follows at once.
- RD_RESP to RD_IDLE when no read follows.

Top module: `msi_coalescer`

## Requirements
- R1: A vector v is written at offset (group<<19)|(index<<16) with data bit, where group = v mod 16, bit = (v/16) mod 21 and index = v/336. The offset decodes as offset[22:19] = group and offset[18:16] = index, with every other offset bit zero. This gives 16 groups × 8 registers × 21 bits.
- R2: A valid write with data 0..20 sets that one pending bit. Bits that are already pending are kept.
- R3: A read at offset 0x800000|(group<<16) returns the group's summary in rd_data[7:0]. Bit i is 1 when index register i has any pending bit. This read clears nothing.
- R4: A read of an index register returns its pending bits in rd_data[20:0] and clears them. The response appears with rd_rdy high in the cycle after the rd_valid cycle.
- R5: If a write sets a bit in the register that is being read in the same cycle, the read returns the old bits. The new bit stays pending.
- R6: A write is ignored, and err_count increments (saturating) when any of these holds:
  - its data is 21 or more;
  - offset bit 23 is set;
  - an offset bit outside [22:16] is set.
- R7: irq_out[g] is a registered signal. It goes high one clock after group g has any pending bit while irq_en[g] is 1, and it goes low one clock after the group empties.
- R8: Clearing irq_en[g] forces irq_out[g] low and discards no pending bit. Setting it again raises the line.
- R9: Reset clears all pending bits, all summary bits, irq_out, err_count and rd_rdy.
- R10: A read at an offset that maps to no register returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Message write strobe |
| wr_offset | input | 24 | Write offset within the message window |
| wr_data | input | 32 | Write data, a bit number |
| rd_valid | input | 1 | Software read request |
| rd_offset | input | 24 | Read offset |
| rd_rdy | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_en | input | 16 | Per-group line enable |
| irq_out | output | 16 | Coalesced interrupt lines |
| err_count | output | 8 | Count of rejected writes |

## Verification
The assertions take for granted three things about the inputs:
- rst_n is asserted at time zero;
- the enable mask is a defined value;
- rd_valid is low during reset, so the request-to-response rule starts from a known state.

The stimulus drives every input on the falling edge. It holds wr_valid and rd_valid for exactly one rising edge per operation. It keeps the enable mask stable except where the masking rule is being exercised.

// File: rtl/msi_coal_pkg.sv
package msi_coal_pkg;
    localparam int OFF_W       = 24;
    localparam int WIN_LSB     = 16;
    localparam int SUM_SEL_BIT = 23;

    typedef enum logic [0:0] {
        RD_IDLE,
        RD_RESP
    } rd_state_e;
endpackage

// File: rtl/msi_wr_decode.sv
module msi_wr_decode
    import msi_coal_pkg::*;
#(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 21,
    parameter int DATA_W        = 32,
    parameter int GRP_W         = 4,
    parameter int IDX_W         = 3,
    parameter int BIT_W         = 5
) (
    input  logic              wr_valid,
    input  logic [OFF_W-1:0]  wr_offset,
    input  logic [DATA_W-1:0] wr_data,
    output logic              set_vld,
    output logic              set_bad,
    output logic [GRP_W-1:0]  set_grp,
    output logic [IDX_W-1:0]  set_idx,
    output logic [BIT_W-1:0]  set_bit
);
    localparam logic [OFF_W-1:0] FIELD_MASK =
        OFF_W'(((64'd1 << (GRP_W + IDX_W)) - 64'd1) << WIN_LSB);

    logic legal;

    always_comb begin
        set_grp = wr_offset[WIN_LSB+IDX_W +: GRP_W];
        set_idx = wr_offset[WIN_LSB +: IDX_W];
        set_bit = wr_data[BIT_W-1:0];
        legal   = ((wr_offset & ~FIELD_MASK) == '0)
               && (int'(set_grp) < NUM_GROUPS)
               && (int'(set_idx) < IDX_PER_GROUP)
               && (wr_data < DATA_W'(BITS_PER_IDX));
        set_vld = wr_valid && legal;
        set_bad = wr_valid && !legal;
    end
endmodule

// File: rtl/msi_pend_bank.sv
module msi_pend_bank #(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 21,
    parameter int GRP_W         = 4,
    parameter int IDX_W         = 3,
    parameter int BIT_W         = 5,
    localparam int NREG         = NUM_GROUPS * IDX_PER_GROUP
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         set_vld,
    input  logic [GRP_W-1:0]             set_grp,
    input  logic [IDX_W-1:0]             set_idx,
    input  logic [BIT_W-1:0]             set_bit,
    input  logic                         clr_vld,
    input  logic [GRP_W-1:0]             clr_grp,
    input  logic [IDX_W-1:0]             clr_idx,
    output logic [NREG*BITS_PER_IDX-1:0] pend_flat,
    output logic [NREG-1:0]              summary_flat
);
    logic [BITS_PER_IDX-1:0] set_onehot;
    assign set_onehot = BITS_PER_IDX'(1) << set_bit;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar i = 0; i < IDX_PER_GROUP; i++) begin : g_idx
            localparam int R = g * IDX_PER_GROUP + i;
            logic [BITS_PER_IDX-1:0] bits_q;
            logic set_hit;
            logic clr_hit;

            assign set_hit = set_vld && (set_grp == GRP_W'(g)) && (set_idx == IDX_W'(i));
            assign clr_hit = clr_vld && (clr_grp == GRP_W'(g)) && (clr_idx == IDX_W'(i));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bits_q <= '0;
                end else if (set_hit || clr_hit) begin
                    bits_q <= (clr_hit ? '0 : bits_q) | (set_hit ? set_onehot : '0);
                end
            end

            assign pend_flat[R*BITS_PER_IDX +: BITS_PER_IDX] = bits_q;
            assign summary_flat[R] = |bits_q;
        end
    end
endmodule

// File: rtl/msi_rd_fsm.sv
module msi_rd_fsm
    import msi_coal_pkg::*;
#(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 21,
    parameter int DATA_W        = 32,
    parameter int GRP_W         = 4,
    parameter int IDX_W         = 3,
    localparam int NREG         = NUM_GROUPS * IDX_PER_GROUP
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_valid,
    input  logic [OFF_W-1:0]             rd_offset,
    input  logic [NREG*BITS_PER_IDX-1:0] pend_flat,
    input  logic [NREG-1:0]              summary_flat,
    output logic                         clr_vld,
    output logic [GRP_W-1:0]             clr_grp,
    output logic [IDX_W-1:0]             clr_idx,
    output logic                         rd_rdy,
    output logic [DATA_W-1:0]            rd_data
);
    localparam logic [OFF_W-1:0] IDX_MASK =
        OFF_W'(((64'd1 << (GRP_W + IDX_W)) - 64'd1) << WIN_LSB);
    localparam logic [OFF_W-1:0] SUM_MASK =
        OFF_W'((64'd1 << SUM_SEL_BIT) | (((64'd1 << GRP_W) - 64'd1) << WIN_LSB));

    rd_state_e        state_q, state_d;
    logic             is_idx, is_sum;
    logic [GRP_W-1:0] sum_grp;
    logic [DATA_W-1:0] sel_data;

    always_comb begin
        clr_grp = rd_offset[WIN_LSB+IDX_W +: GRP_W];
        clr_idx = rd_offset[WIN_LSB +: IDX_W];
        sum_grp = rd_offset[WIN_LSB +: GRP_W];
        is_idx  = ((rd_offset & ~IDX_MASK) == '0)
               && (int'(clr_grp) < NUM_GROUPS)
               && (int'(clr_idx) < IDX_PER_GROUP);
        is_sum  = rd_offset[SUM_SEL_BIT]
               && ((rd_offset & ~SUM_MASK) == '0)
               && (int'(sum_grp) < NUM_GROUPS);
        clr_vld = rd_valid && is_idx;
        if (is_idx)
            sel_data = DATA_W'(pend_flat[(int'(clr_grp) * IDX_PER_GROUP + int'(clr_idx))
                                         * BITS_PER_IDX +: BITS_PER_IDX]);
        else if (is_sum)
            sel_data = DATA_W'(summary_flat[int'(sum_grp) * IDX_PER_GROUP +: IDX_PER_GROUP]);
        else
            sel_data = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_valid)  state_d = RD_RESP;
            RD_RESP: if (!rd_valid) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_data <= '0;
        else if (rd_valid) rd_data <= sel_data;
    end

    assign rd_rdy = (state_q == RD_RESP);
endmodule

// File: rtl/msi_irq_out.sv
module msi_irq_out #(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    localparam int NREG         = NUM_GROUPS * IDX_PER_GROUP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREG-1:0]       summary_flat,
    input  logic [NUM_GROUPS-1:0] irq_en,
    output logic [NUM_GROUPS-1:0] irq_out
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_out[g] <= 1'b0;
            else        irq_out[g] <= irq_en[g] && (|summary_flat[g*IDX_PER_GROUP +: IDX_PER_GROUP]);
        end
    end
endmodule

// File: rtl/msi_coalescer.sv
module msi_coalescer
    import msi_coal_pkg::*;
#(
    parameter int NUM_GROUPS    = 16,
    parameter int IDX_PER_GROUP = 8,
    parameter int BITS_PER_IDX  = 21,
    parameter int DATA_W        = 32,
    parameter int ERR_W         = 8,
    localparam int GRP_W        = $clog2(NUM_GROUPS),
    localparam int IDX_W        = $clog2(IDX_PER_GROUP),
    localparam int BIT_W        = $clog2(BITS_PER_IDX),
    localparam int NREG         = NUM_GROUPS * IDX_PER_GROUP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [OFF_W-1:0]      wr_offset,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_valid,
    input  logic [OFF_W-1:0]      rd_offset,
    output logic                  rd_rdy,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [NUM_GROUPS-1:0] irq_en,
    output logic [NUM_GROUPS-1:0] irq_out,
    output logic [ERR_W-1:0]      err_count
);
    logic                         set_vld, set_bad, clr_vld;
    logic [GRP_W-1:0]             set_grp, clr_grp;
    logic [IDX_W-1:0]             set_idx, clr_idx;
    logic [BIT_W-1:0]             set_bit;
    logic [NREG*BITS_PER_IDX-1:0] pend_flat;
    logic [NREG-1:0]              summary_flat;

    msi_wr_decode #(
        .NUM_GROUPS(NUM_GROUPS), .IDX_PER_GROUP(IDX_PER_GROUP), .BITS_PER_IDX(BITS_PER_IDX),
        .DATA_W(DATA_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .BIT_W(BIT_W)
    ) u_dec (
        .wr_valid(wr_valid), .wr_offset(wr_offset), .wr_data(wr_data),
        .set_vld(set_vld), .set_bad(set_bad), .set_grp(set_grp),
        .set_idx(set_idx), .set_bit(set_bit)
    );

    msi_pend_bank #(
        .NUM_GROUPS(NUM_GROUPS), .IDX_PER_GROUP(IDX_PER_GROUP), .BITS_PER_IDX(BITS_PER_IDX),
        .GRP_W(GRP_W), .IDX_W(IDX_W), .BIT_W(BIT_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_grp(set_grp), .set_idx(set_idx), .set_bit(set_bit),
        .clr_vld(clr_vld), .clr_grp(clr_grp), .clr_idx(clr_idx),
        .pend_flat(pend_flat), .summary_flat(summary_flat)
    );

    msi_rd_fsm #(
        .NUM_GROUPS(NUM_GROUPS), .IDX_PER_GROUP(IDX_PER_GROUP), .BITS_PER_IDX(BITS_PER_IDX),
        .DATA_W(DATA_W), .GRP_W(GRP_W), .IDX_W(IDX_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_offset(rd_offset),
        .pend_flat(pend_flat), .summary_flat(summary_flat),
        .clr_vld(clr_vld), .clr_grp(clr_grp), .clr_idx(clr_idx),
        .rd_rdy(rd_rdy), .rd_data(rd_data)
    );

    msi_irq_out #(
        .NUM_GROUPS(NUM_GROUPS), .IDX_PER_GROUP(IDX_PER_GROUP)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .summary_flat(summary_flat),
        .irq_en(irq_en), .irq_out(irq_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          err_count <= '0;
        else if (set_bad && err_count != '1) err_count <= err_count + ERR_W'(1);
    end
endmodule

// File: rtl/msi_coalescer_chk.sv
module msi_coalescer_chk #(
    parameter int NUM_GROUPS = 16,
    parameter int ERR_W      = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_valid,
    input logic                  rd_rdy,
    input logic [NUM_GROUPS-1:0] irq_en,
    input logic [NUM_GROUPS-1:0] irq_out,
    input logic [ERR_W-1:0]      err_count
);
    AST_RDY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_rdy); // R4
    AST_NO_RDY_UNREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_rdy); // R4
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(irq_en)) == '0); // R7
    AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        err_count >= $past(err_count)); // R6
    AST_ERR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count - $past(err_count)) <= ERR_W'(1)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && err_count == '0 && !rd_rdy)); // R9
endmodule

bind msi_coalescer msi_coalescer_chk #(
    .NUM_GROUPS(NUM_GROUPS), .ERR_W(ERR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_rdy(rd_rdy),
    .irq_en(irq_en), .irq_out(irq_out), .err_count(err_count)
);

// File: tb/msi_coalescer_test.sv
module msi_coalescer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_offset = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_offset = '0;
    logic        rd_rdy;
    logic [31:0] rd_data;
    logic [15:0] irq_en = '1;
    logic [15:0] irq_out;
    logic [7:0]  err_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_rd;

    always #4 clk = ~clk;

    msi_coalescer uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_offset(wr_offset),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_offset(rd_offset),
        .rd_rdy(rd_rdy), .rd_data(rd_data), .irq_en(irq_en),
        .irq_out(irq_out), .err_count(err_count)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] idx_off(input int g, input int i);
        return 24'((g << 19) | (i << 16));
    endfunction

    function automatic logic [23:0] sum_off(input int g);
        return 24'(24'h800000 | (g << 16));
    endfunction

    task automatic do_write(input logic [23:0] off, input logic [31:0] d);
        wr_valid = 1'b1; wr_offset = off; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [23:0] off, input logic [31:0] exp, input string req);
        rd_valid = 1'b1; rd_offset = off;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(posedge clk); @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic do_rdwr(input logic [23:0] off, input logic [31:0] d, input logic [31:0] exp, input string req);
        wr_valid = 1'b1; wr_offset = off; wr_data = d;
        rd_valid = 1'b1; rd_offset = off;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    // Monitor: pops the scoreboard whenever a response is presented
    always @(negedge clk) begin
        if (rst_n && rd_rdy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected response", rd_data, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                last_rd = rd_data;
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, g, i, b;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(irq_out == 16'h0, "R9 irq after reset", 32'(irq_out), 0);
        check(err_count == 8'h0, "R9 err after reset", 32'(err_count), 0);
        check(rd_rdy == 1'b0, "R9 rdy after reset", 32'(rd_rdy), 0);
        rst_n = 1'b1;
        settle();
        do_read(sum_off(0), 32'h0, "R9 summary empty after reset");

        // R1: vector 1000 -> group 8, index 2, bit 20
        v = 1000; g = v % 16; b = (v / 16) % 21; i = v / 336;
        do_write(idx_off(g, i), 32'(b));
        check(err_count == 0, "R1 legal write not counted", 32'(err_count), 0);
        settle();
        check(irq_out == 16'h0100, "R7 line up for group 8", 32'(irq_out), 32'h0100);
        do_read(sum_off(g), 32'h4, "R3 summary flags index 2");
        do_read(sum_off(g), 32'h4, "R3 summary read does not clear");
        do_read(idx_off(g, i), 32'h0010_0000, "R4 index read returns bit 20");
        settle();
        check(((2 * 21 + 20) * 16) + 8 == 1000, "R1 vector rebuild", 32'(((2 * 21 + 20) * 16) + 8), 1000);
        do_read(idx_off(g, i), 32'h0, "R4 index read cleared");
        settle();
        check(irq_out == 16'h0, "R7 line drops after clear", 32'(irq_out), 0);

        // R2: accumulation within one register
        do_write(idx_off(3, 7), 32'd0);
        do_write(idx_off(3, 7), 32'd5);
        do_read(idx_off(3, 7), 32'h21, "R2 bits 0 and 5 accumulate");

        // R1: extreme vectors 0 and 2687
        do_write(idx_off(0, 0), 32'd0);
        do_write(idx_off(15, 7), 32'd20);
        settle();
        check(irq_out == 16'h8001, "R1 extreme vectors lines", 32'(irq_out), 32'h8001);
        do_read(sum_off(15), 32'h80, "R1 vector 2687 summary");
        do_read(idx_off(15, 7), 32'h0010_0000, "R1 vector 2687 bit");
        do_read(idx_off(0, 0), 32'h1, "R1 vector 0 bit");
        settle();

        // R8: masking keeps pending state
        irq_en[5] = 1'b0;
        do_write(idx_off(5, 1), 32'd3);
        settle();
        check(irq_out[5] == 1'b0, "R8 masked line low", 32'(irq_out), 0);
        irq_en[5] = 1'b1;
        settle();
        check(irq_out[5] == 1'b1, "R8 unmask raises line", 32'(irq_out), 32'h20);
        do_read(idx_off(5, 1), 32'h8, "R8 pending kept under mask");

        // R6: malformed writes
        do_write(idx_off(2, 0), 32'd21);
        check(err_count == 8'd1, "R6 data 21 rejected", 32'(err_count), 1);
        do_write(24'h800000, 32'd1);
        check(err_count == 8'd2, "R6 summary region write rejected", 32'(err_count), 2);
        do_write(24'h000004, 32'd1);
        check(err_count == 8'd3, "R6 low offset bits rejected", 32'(err_count), 3);
        settle();
        check(irq_out == 16'h0, "R6 no line from rejected writes", 32'(irq_out), 0);
        do_read(sum_off(2), 32'h0, "R6 group 2 stays empty");
        do_read(sum_off(0), 32'h0, "R6 group 0 stays empty");

        // R5: write and read-clear on the same register in one cycle
        do_write(idx_off(4, 2), 32'd1);
        do_rdwr(idx_off(4, 2), 32'd9, 32'h2, "R5 read returns old bits");
        do_read(idx_off(4, 2), 32'h200, "R5 same-cycle bit kept");

        // R10: unmapped reads
        do_write(idx_off(6, 0), 32'd2);
        do_read(idx_off(6, 0) | 24'h4, 32'h0, "R10 unmapped offset reads zero");
        do_read(24'h800001, 32'h0, "R10 unmapped summary offset reads zero");
        do_read(idx_off(6, 0), 32'h4, "R10 unmapped read cleared nothing");
        settle();
        settle();
        check(exp_q.size() == 0, "R4 all responses seen", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule